// File: doc/BRIEF.md
# Three-Channel Tone and Noise Level Mixer

This block produces the per-channel amplitude codes of a three-voice sound generator. Each voice has its own square-wave tone divider with a 12-bit half-period. All three voices share one pseudo-random noise source with a 5-bit period. A mixer stage gates the selected amplitude on or off from the tone and noise bits. Two mask bits per voice control that gate, and a mask bit at 1 removes its source from the gate.

The amplitude for each voice is either a fixed 4-bit level or an external 4-bit envelope code, selected per voice. The three 4-bit outputs are meant to drive logarithmic converters outside this block. All inputs are plain decoded control fields held by a register file elsewhere. No data is streamed into or out of the block, so no port has a valid/ready handshake and no back-pressure applies. Each output follows the internal tone and noise state and the control fields every cycle.

Top module: `psg_tone_noise_mixer`

## Requirements
- R1: A shared prescaler produces one tick every 16 clocks. After `rst_n` is released, the first tick falls on the 16th rising edge.
- R2: After reset, each tone bit is low. It first inverts on the first tick. After that, it inverts once every P ticks, where P is the tone period captured at the previous inversion. One full square wave therefore lasts 32×P clocks. A new period takes effect only at the next inversion.
- R3: A tone or noise period field of 0 behaves exactly like a period of 1.
- R4: The noise source is a 17-bit shift register seeded with 1 at reset. When the noise period expires, the register shifts right by one and bit 16 takes bit0 XOR bit3. The noise bit is bit 0. The noise period uses the same tick, first expiry and capture rule as the tone period.
- R5: `mix_off` bits 0, 1 and 2 remove the tone from voices A, B and C. Bits 3, 4 and 5 remove the noise from voices A, B and C. A value of 1 removes the source and 0 keeps it.
- R6: A voice's gate is (tone OR tone_off) AND (noise OR noise_off). When the gate is 1 the output carries the selected amplitude, and when it is 0 the output is 0. With both masks set, the selected amplitude appears constantly.
- R7: `amp_env_mode` bit n at 1 selects `env_level` for voice n. At 0 it selects `amp_fixed` for voice n.
- R8: All three voices see the same noise bit in the same cycle.
- R9: While `rst_n` is low, every tone bit is 0 and the noise bit is 1. Outputs still follow R6 and R7 from that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tone_period | input | 3×12 | Tone half-period per voice, voice A in index 0 |
| noise_period | input | 5 | Shared noise period |
| mix_off | input | 6 | Tone masks in bits 2:0, noise masks in bits 5:3, 1 removes the source |
| amp_env_mode | input | 3 | Per-voice amplitude source select, 1 selects the envelope |
| amp_fixed | input | 3×4 | Per-voice fixed amplitude |
| env_level | input | 4 | External envelope code |
| level_out | output | 3×4 | Per-voice amplitude code |

## Verification
A tone inversion and a noise shift can fall on the same prescaler tick. When they do, the gate changes through both terms in one cycle. The stimulus provokes this with short periods, such as equal tone and noise periods of 1 and periods of 0. Under those settings the two dividers expire together on most ticks. A cycle-accurate reference model built from the requirements judges every output in every cycle. This includes the cycles where a mask, a mode bit or a period changes on the same edge as a tick.

// File: rtl/psg_pkg.sv
package psg_pkg;
  localparam int NUM_VOICE  = 3;
  localparam int TONE_BITS  = 12;
  localparam int NOISE_BITS = 5;
  localparam int AMP_BITS   = 4;
  localparam int PRE_DIV    = 16;
  localparam int LFSR_BITS  = 17;
  localparam int LFSR_TAP   = 3;
  localparam logic [LFSR_BITS-1:0] LFSR_SEED = LFSR_BITS'(1);
endpackage

// File: rtl/psg_prescaler.sv
module psg_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  // R1: ticks are never back to back
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/psg_period_div.sv
module psg_period_div #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [W-1:0] period_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cur_q;
  logic [W-1:0] per_eff;
  logic         at_end;

  // R3: a zero period is treated as one
  assign per_eff  = (period_i == '0) ? W'(1) : period_i;
  assign at_end   = (cnt_q >= cur_q - 1'b1);
  assign expire_o = tick_i && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cur_q <= W'(1);
    end else if (tick_i) begin
      if (at_end) begin
        cnt_q <= '0;
        cur_q <= per_eff;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_cur_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q != '0);
  assert_expire_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/psg_noise_src.sv
module psg_noise_src
  import psg_pkg::*;
#(
  parameter int PW = NOISE_BITS,
  parameter int LW = LFSR_BITS,
  parameter int TAP = LFSR_TAP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [PW-1:0] period_i,
  output logic          noise_o
);
  logic          step;
  logic [LW-1:0] lfsr_q;

  psg_period_div #(.W(PW)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .period_i(period_i), .expire_o(step)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    lfsr_q <= LW'(LFSR_SEED);
    else if (step) lfsr_q <= {lfsr_q[0] ^ lfsr_q[TAP], lfsr_q[LW-1:1]};
  end

  assign noise_o = lfsr_q[0];

  // R4: register only moves on a divider expiry and never locks up at zero
  assert_lfsr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(lfsr_q));
  assert_lfsr_alive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

// File: rtl/psg_tone_voice.sv
module psg_tone_voice #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [W-1:0] period_i,
  output logic         tone_o
);
  logic flip;
  logic tone_q;

  psg_period_div #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .period_i(period_i), .expire_o(flip)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    tone_q <= 1'b0;
    else if (flip) tone_q <= ~tone_q;
  end

  assign tone_o = tone_q;

  // R2: the square wave only changes on a prescaler tick
  assert_tone_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(tone_q));
endmodule

// File: rtl/psg_mix_voice.sv
module psg_mix_voice #(
  parameter int AW = 4
) (
  input  logic          tone_i,
  input  logic          noise_i,
  input  logic          tone_off_i,
  input  logic          noise_off_i,
  input  logic          env_mode_i,
  input  logic [AW-1:0] fixed_i,
  input  logic [AW-1:0] env_i,
  output logic [AW-1:0] level_o
);
  logic          gate;
  logic [AW-1:0] amp;

  always_comb begin
    gate    = (tone_i | tone_off_i) & (noise_i | noise_off_i);
    amp     = env_mode_i ? env_i : fixed_i;
    level_o = gate ? amp : '0;
  end
endmodule

// File: rtl/psg_tone_noise_mixer.sv
module psg_tone_noise_mixer
  import psg_pkg::*;
#(
  parameter int NV = NUM_VOICE,
  parameter int TW = TONE_BITS,
  parameter int NW = NOISE_BITS,
  parameter int AW = AMP_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NV-1:0][TW-1:0] tone_period,
  input  logic [NW-1:0]         noise_period,
  input  logic [2*NV-1:0]       mix_off,
  input  logic [NV-1:0]         amp_env_mode,
  input  logic [NV-1:0][AW-1:0] amp_fixed,
  input  logic [AW-1:0]         env_level,
  output logic [NV-1:0][AW-1:0] level_out
);
  logic          tick;
  logic          noise;
  logic [NV-1:0] tone;

  psg_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  psg_noise_src #(.PW(NW)) u_noise (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .period_i(noise_period), .noise_o(noise)
  );

  for (genvar v = 0; v < NV; v++) begin : g_voice
    psg_tone_voice #(.W(TW)) u_tone (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .period_i(tone_period[v]), .tone_o(tone[v])
    );

    psg_mix_voice #(.AW(AW)) u_mix (
      .tone_i(tone[v]), .noise_i(noise),
      .tone_off_i(mix_off[v]), .noise_off_i(mix_off[NV+v]),
      .env_mode_i(amp_env_mode[v]), .fixed_i(amp_fixed[v]),
      .env_i(env_level), .level_o(level_out[v])
    );

    // R7: a voice only ever shows zero or its selected source
    assert_level_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (level_out[v] == '0) ||
      (level_out[v] == (amp_env_mode[v] ? env_level : amp_fixed[v])));
    // R6: fully masked voice carries its amplitude constantly
    assert_masked_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mix_off[v] && mix_off[NV+v]) |->
      (level_out[v] == (amp_env_mode[v] ? env_level : amp_fixed[v])));
  end
endmodule

// File: tb/psg_tone_noise_mixer_test.sv
`timescale 1ns/1ps
module psg_tone_noise_mixer_test;
  localparam int NV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NV-1:0][11:0] tone_period = '0;
  logic [4:0]          noise_period = '0;
  logic [5:0]          mix_off = '1;
  logic [NV-1:0]       amp_env_mode = '0;
  logic [NV-1:0][3:0]  amp_fixed = '0;
  logic [3:0]          env_level = '0;
  logic [NV-1:0][3:0]  level_out;

  int total = 0;
  int bad = 0;
  string tag = "R9";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  psg_tone_noise_mixer uut (
    .clk(clk), .rst_n(rst_n), .tone_period(tone_period),
    .noise_period(noise_period), .mix_off(mix_off),
    .amp_env_mode(amp_env_mode), .amp_fixed(amp_fixed),
    .env_level(env_level), .level_out(level_out)
  );

  // reference model written from the requirements
  int m_pre;
  int t_cnt [NV];
  int t_cur [NV];
  bit t_bit [NV];
  int n_cnt, n_cur;
  bit [16:0] n_reg;

  function automatic int eff(int p);
    return (p == 0) ? 1 : p;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; n_cnt = 0; n_cur = 1; n_reg = 17'd1;
      for (int v = 0; v < NV; v++) begin t_cnt[v] = 0; t_cur[v] = 1; t_bit[v] = 0; end
    end else begin
      bit tk;
      tk = (m_pre == 15);
      m_pre = (m_pre + 1) % 16;
      if (tk) begin
        for (int v = 0; v < NV; v++) begin
          if (t_cnt[v] >= t_cur[v] - 1) begin
            t_cnt[v] = 0; t_cur[v] = eff(int'(tone_period[v])); t_bit[v] = !t_bit[v];
          end else t_cnt[v]++;
        end
        if (n_cnt >= n_cur - 1) begin
          n_cnt = 0; n_cur = eff(int'(noise_period));
          n_reg = {n_reg[0] ^ n_reg[3], n_reg[16:1]};
        end else n_cnt++;
      end
    end
  end

  function automatic logic [3:0] exp_level(int v);
    bit g;
    g = (t_bit[v] | mix_off[v]) & (n_reg[0] | mix_off[NV+v]);
    if (!g) return 4'd0;
    return amp_env_mode[v] ? env_level : amp_fixed[v];
  endfunction

  task automatic check_all();
    for (int v = 0; v < NV; v++) begin
      logic [3:0] e;
      e = exp_level(v);
      total++;
      if (level_out[v] !== e) begin
        bad++;
        $display("FAIL %s voice %0d: got %0d expected %0d at %0t", tag, v, level_out[v], e, $time);
      end
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all();
    end
  endtask

  task automatic expect_val(string t, int v, logic [3:0] e);
    total++;
    if (level_out[v] !== e) begin
      bad++;
      $display("FAIL %s voice %0d: got %0d expected %0d", t, v, level_out[v], e);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    // R9: reset state, tone enabled on A, noise enabled on B
    mix_off = 6'b101_110;
    amp_fixed = {4'd3, 4'd5, 4'd9};
    run(4);
    expect_val("R9", 0, 4'd0);   // tone low during reset
    expect_val("R9", 1, 4'd5);   // noise bit high during reset
    // R1 R2: tone on A only, period 1: first rise on 16th edge after release
    tag = "R1 R2";
    mix_off = 6'b111_110;
    tone_period[0] = 12'd1;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      check_all();
      if (i == 15) expect_val("R1", 0, 4'd0);
      if (i == 16) expect_val("R1", 0, 4'd9);
    end
    tone_period = {12'd3, 12'd2, 12'd1};
    mix_off = 6'b111_000;
    run(600);
    // R2: period change mid-wave takes effect at next inversion
    tone_period[1] = 12'd5;
    run(400);
    // R3: period zero behaves like one
    tag = "R3";
    tone_period = {12'd0, 12'd1, 12'd0};
    noise_period = 5'd0;
    run(400);
    // R4 R8: noise only on all voices, same noise bit everywhere
    tag = "R4 R8";
    mix_off = 6'b000_111;
    amp_fixed = {4'd15, 4'd15, 4'd15};
    noise_period = 5'd1;
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      check_all();
      total++;
      if (level_out[0] !== level_out[1] || level_out[1] !== level_out[2]) begin
        bad++;
        $display("FAIL R8: got %0d/%0d/%0d expected equal", level_out[0], level_out[1], level_out[2]);
      end
    end
    noise_period = 5'd31;
    run(1200);
    // R5 R6: both masks set gives constant level; tone and noise together
    tag = "R5 R6";
    mix_off = 6'b001_001;
    noise_period = 5'd1;
    tone_period = {12'd1, 12'd1, 12'd1};
    amp_fixed = {4'd7, 4'd11, 4'd13};
    run(4);
    expect_val("R6", 0, 4'd13);
    mix_off = 6'b000_000;
    run(600);
    // R7: envelope source
    tag = "R7";
    mix_off = 6'b111_111;
    amp_env_mode = 3'b101;
    env_level = 4'd6;
    run(2);
    expect_val("R7", 0, 4'd6);
    expect_val("R7", 1, 4'd11);
    expect_val("R7", 2, 4'd6);
    env_level = 4'd12;
    run(2);
    expect_val("R7", 2, 4'd12);
    // random mix with coinciding expiries
    tag = "R2 R4 R6 R7";
    for (int k = 0; k < 60; k++) begin
      for (int v = 0; v < NV; v++) begin
        tone_period[v] = 12'($urandom_range(0, 6));
        amp_fixed[v] = 4'($urandom_range(0, 15));
      end
      noise_period = 5'($urandom_range(0, 3));
      mix_off = 6'($urandom_range(0, 63));
      amp_env_mode = 3'($urandom_range(0, 7));
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        check_all();
        if (i % 37 == 0) env_level = 4'($urandom_range(0, 15));
      end
    end
    // mid-run reset returns to R9 state
    tag = "R9";
    mix_off = 6'b111_000;
    amp_env_mode = '0;
    amp_fixed = {4'd2, 4'd2, 4'd2};
    rst_n = 1'b0;
    run(3);
    expect_val("R9", 0, 4'd0);
    rst_n = 1'b1;
    run(100);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule